// File: doc/BRIEF.md
# Sleep Mode Power-Down Sequencer

This block takes a microcontroller into its low-power halt state and brings it back out. The core raises `sleep_req` for one cycle when it executes its halt instruction. On that cycle the sequencer updates two status flags and restarts the watchdog count from zero without stopping the watchdog. It also switches off the primary oscillator driver, clears any pending clock-failure flag, and captures every I/O output value and output-enable bit. The pins then keep exactly that drive, whether high, low or high-impedance, however the core's I/O registers move.

The halt ends on an external wake event or on a watchdog timeout. A timeout during the halt also clears the timeout flag, so firmware can tell which source woke it. On wake the oscillator driver is switched back on at once. The core clock stays gated for a fixed start-up interval, and only then are `core_ready` and live pin control handed back to the core.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, `stat_pd` and `stat_to` are 1, `fail_pending` is 0, `asleep` is 0, `osc_drv_en` is 1 and `core_ready` is 1.
- R2: A `sleep_req` sampled while awake enters the halt at that clock edge: `asleep` becomes 1, `stat_pd` (power-down flag, status bit 3) becomes 0 and `stat_to` (timeout flag, status bit 4) becomes 1.
- R3: Entry resets the watchdog count to 0. With `wdt_en` high the count keeps advancing by one per cycle during the halt. `wdt_timeout` pulses for one cycle when the count reaches `WDT_LIMIT-1`, and the count then wraps to 0.
- R4: `osc_drv_en` is 0 for exactly the cycles in which `asleep` is 1.
- R5: From entry until `core_ready` returns, `pin_out` and `pin_oe` hold the `core_out` and `core_oe` values sampled at the entry edge. An enable bit of 0 means high-impedance. While running, the pins follow `core_out` and `core_oe` directly.
- R6: `clk_fail` sets `fail_pending`, and entry into the halt clears it. When both happen on the same edge, entry wins.
- R7: A `wdt_timeout` while asleep wakes the block at that edge and clears `stat_to` to 0. A timeout while running also clears `stat_to`.
- R8: After a wake edge, `osc_drv_en` is 1 at once, and `core_ready` rises exactly `OST_CYCLES` clock edges after the wake edge.
- R9: `sleep_req` is ignored while asleep or starting up, and `wake_evt` is ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| sleep_req | input | 1 | halt instruction executed |
| wake_evt | input | 1 | external wake source |
| wdt_en | input | 1 | watchdog enable |
| clk_fail | input | 1 | clock-failure detected |
| core_out | input | IO_W | core I/O output values |
| core_oe | input | IO_W | core I/O output enables |
| pin_out | output | IO_W | pin output values |
| pin_oe | output | IO_W | pin output enables (0 = high-impedance) |
| osc_drv_en | output | 1 | primary oscillator driver enable |
| core_ready | output | 1 | core clock released |
| asleep | output | 1 | in halt state |
| stat_pd | output | 1 | power-down status flag |
| stat_to | output | 1 | timeout status flag |
| wdt_timeout | output | 1 | watchdog expiry pulse |
| fail_pending | output | 1 | clock-failure flag |

## Verification
The halt is entered with one byte pattern driven out and a different one present afterwards, and with a mix of enabled and disabled lanes. This separates a pin that is really held from one that follows the core, and a held high-impedance lane from a driven one. Three exits are exercised: an external wake, a watchdog expiry, and a long halt with the watchdog off that has to stay asleep. Together they separate the two wake sources by the `stat_to` flag. Requests made during start-up and wakes made while running show that the wrong-state inputs are ignored. A clock failure raised just before entry shows that entry clears the flag.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_START = 2'd2
  } pwr_state_e;

  // a counter of modulus lim has reached its final value
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

endpackage

// File: rtl/sleep_wdt.sv
module sleep_wdt #(
  parameter int unsigned LIMIT = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic timeout
);
  import sleep_ctrl_pkg::*;
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  assign timeout = en && at_last(int'(cnt), LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (en) begin
      if (timeout)    cnt <= '0;
      else            cnt <= cnt + 1'b1;
    end
  end

  // R3: entry restarts the count from zero
  p_wdt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/sleep_ost.sv
module sleep_ost #(
  parameter int unsigned CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import sleep_ctrl_pkg::*;
  localparam int unsigned W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt;

  assign done = run && at_last(int'(cnt), CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  // R8: sequencer leaves start-up right after expiry
  p_start_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run);

endmodule

// File: rtl/sleep_io_hold.sv
module sleep_io_hold #(
  parameter int unsigned IO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            hold,
  input  logic [IO_W-1:0] core_out,
  input  logic [IO_W-1:0] core_oe,
  output logic [IO_W-1:0] pin_out,
  output logic [IO_W-1:0] pin_oe
);
  logic [IO_W-1:0] held_out, held_oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_out <= '0;
      held_oe  <= '0;
    end else if (capture) begin
      held_out <= core_out;
      held_oe  <= core_oe;
    end
  end

  for (genvar i = 0; i < IO_W; i++) begin : g_lane
    assign pin_out[i] = hold ? held_out[i] : core_out[i];
    assign pin_oe[i]  = hold ? held_oe[i]  : core_oe[i];
  end

  // R5: pins frozen across the whole hold window
  p_pins_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl #(
  parameter int unsigned IO_W       = 8,
  parameter int unsigned WDT_LIMIT  = 48,
  parameter int unsigned OST_CYCLES = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            wake_evt,
  input  logic            wdt_en,
  input  logic            clk_fail,
  input  logic [IO_W-1:0] core_out,
  input  logic [IO_W-1:0] core_oe,
  output logic [IO_W-1:0] pin_out,
  output logic [IO_W-1:0] pin_oe,
  output logic            osc_drv_en,
  output logic            core_ready,
  output logic            asleep,
  output logic            stat_pd,
  output logic            stat_to,
  output logic            wdt_timeout,
  output logic            fail_pending
);
  import sleep_ctrl_pkg::*;

  pwr_state_e state, state_nx;
  logic enter_ev, wake_ev, ost_done, in_start;

  // named internal events
  assign enter_ev = (state == PS_RUN) && sleep_req;
  assign wake_ev  = (state == PS_SLEEP) && (wake_evt || wdt_timeout);
  assign in_start = (state == PS_START);

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_RUN:   if (enter_ev) state_nx = PS_SLEEP;
      PS_SLEEP: if (wake_ev)  state_nx = PS_START;
      PS_START: if (ost_done) state_nx = PS_RUN;
      default:                state_nx = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= PS_RUN;
      stat_pd      <= 1'b1;
      stat_to      <= 1'b1;
      fail_pending <= 1'b0;
    end else begin
      state <= state_nx;
      if (enter_ev) stat_pd <= 1'b0;
      if (enter_ev)         stat_to <= 1'b1;
      else if (wdt_timeout) stat_to <= 1'b0;
      if (enter_ev)      fail_pending <= 1'b0;
      else if (clk_fail) fail_pending <= 1'b1;
    end
  end

  assign asleep     = (state == PS_SLEEP);
  assign osc_drv_en = (state != PS_SLEEP);
  assign core_ready = (state == PS_RUN);

  sleep_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .clr(enter_ev), .timeout(wdt_timeout)
  );

  sleep_ost #(.CYCLES(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n), .run(in_start), .done(ost_done)
  );

  sleep_io_hold #(.IO_W(IO_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(enter_ev), .hold(!core_ready),
    .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R2: status pattern on entry
  p_entry_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> (!stat_pd && stat_to));

  // R6: entry clears the clock-failure flag
  p_fail_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> !fail_pending);

  // R7: watchdog expiry in the halt wakes and marks the cause
  p_wdt_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wdt_timeout) |=> (!asleep && !stat_to));

  // R4: oscillator back on whenever start-up runs
  p_osc_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (osc_drv_en && !core_ready));

endmodule

// File: tb/tb_sleep_pwr_ctrl.sv
module tb_sleep_pwr_ctrl;
  localparam int N = 8, LIM = 48, OST = 12;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, wake_evt = 0, wdt_en = 0, clk_fail = 0;
  logic [N-1:0] core_out = '0, core_oe = '0;
  logic [N-1:0] pin_out, pin_oe;
  logic osc_drv_en, core_ready, asleep, stat_pd, stat_to, wdt_timeout, fail_pending;

  always #5 clk = ~clk;

  sleep_pwr_ctrl #(.IO_W(N), .WDT_LIMIT(LIM), .OST_CYCLES(OST)) dut (.*);

  typedef struct {
    logic [N-1:0] po, poe;
    logic osc, rdy, slp, pd, to, wto, fp;
  } exp_t;

  exp_t q[$];
  int applied = 0, bad = 0;

  // reference model state: 0 run, 1 halt, 2 start-up
  int m_st = 0, m_wdt = 0, m_ost = 0;
  logic m_pd = 1, m_to = 1, m_fp = 0;
  logic [N-1:0] m_ho = '0, m_hoe = '0;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic sr, input logic we, input logic wen, input logic cf,
                      input logic [N-1:0] o, input logic [N-1:0] oe);
    exp_t e;
    logic wto, enter, wake, done;
    @(posedge clk); #1;
    sleep_req = sr; wake_evt = we; wdt_en = wen; clk_fail = cf; core_out = o; core_oe = oe;
    wto = wen && (m_wdt == LIM - 1);
    e.slp = (m_st == 1); e.osc = (m_st != 1); e.rdy = (m_st == 0);
    e.pd = m_pd; e.to = m_to; e.fp = m_fp; e.wto = wto;
    e.po = (m_st == 0) ? o : m_ho; e.poe = (m_st == 0) ? oe : m_hoe;
    q.push_back(e);
    enter = (m_st == 0) && sr;
    wake  = (m_st == 1) && (we || wto);
    done  = (m_st == 2) && (m_ost == OST - 1);
    if (enter) m_wdt = 0; else if (wen) m_wdt = wto ? 0 : m_wdt + 1;
    if (m_st != 2) m_ost = 0; else if (!done) m_ost++;
    if (enter) m_pd = 0;
    if (enter) m_to = 1; else if (wto) m_to = 0;
    if (enter) m_fp = 0; else if (cf) m_fp = 1;
    if (enter) begin m_ho = o; m_hoe = oe; end
    if (enter) m_st = 1; else if (wake) m_st = 2; else if (done) m_st = 0;
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) if (rst_n && q.size() > 0) begin
    exp_t e;
    e = q.pop_front();
    chk("R5 pin_out", pin_out, e.po);
    chk("R5 pin_oe", pin_oe, e.poe);
    chk("R4 osc_drv_en", N'(osc_drv_en), N'(e.osc));
    chk("R8 core_ready", N'(core_ready), N'(e.rdy));
    chk("R2/R9 asleep", N'(asleep), N'(e.slp));
    chk("R2 stat_pd", N'(stat_pd), N'(e.pd));
    chk("R7 stat_to", N'(stat_to), N'(e.to));
    chk("R3 wdt_timeout", N'(wdt_timeout), N'(e.wto));
    chk("R6 fail_pending", N'(fail_pending), N'(e.fp));
  end

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 status", N'({stat_pd, stat_to, fail_pending, asleep, osc_drv_en, core_ready}),
        N'(6'b110011));
    @(posedge clk); #1; rst_n = 1;
    // running: pins follow the core
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 8'h11 * i, 8'hF0 ^ i);
    step(0, 1, 1, 0, 8'h3C, 8'hFF);            // R9: wake while running ignored
    step(0, 0, 1, 1, 8'h3C, 8'hFF);            // R6: failure flag set
    step(1, 0, 1, 0, 8'hA5, 8'h0F);            // R2 entry, R6 clear, R5 capture
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, ~8'hA5, 8'hF0);   // R5 held
    step(1, 0, 1, 0, 8'h00, 8'h00);            // R9: request while asleep ignored
    step(0, 1, 1, 0, 8'h5A, 8'hFF);            // wake by event
    for (int i = 0; i < OST + 3; i++) step(i == 2, 0, 1, i == 4, 8'h77, 8'h3C); // R8, R9
    step(1, 0, 1, 0, 8'hC3, 8'hAA);            // enter again
    for (int i = 0; i < LIM + OST + 4; i++) step(0, 0, 1, 0, 8'h99, 8'h55);  // R7 wdt wake
    step(1, 0, 0, 0, 8'hE1, 8'h81);            // R3: watchdog off, long halt
    for (int i = 0; i < LIM + 12; i++) step(0, 0, 0, 0, 8'h0E, 8'h7E);
    step(0, 1, 0, 0, 8'h0E, 8'h7E);
    for (int i = 0; i < OST + 2; i++) step(0, 0, 1, 0, 8'h42, 8'h24);
    @(posedge clk); @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule